// File: doc/BRIEF.md
# Memory-Controller Performance Counter Unit

This block watches a memory controller through a set of event pulses and keeps four counters of them. Counter 0 always counts clock cycles, and it acts as the time base for the whole unit. Counters 1 to 3 each count the pulses of one event input, chosen by a select field. Software controls the unit through a small word-addressed register port. That port gives it run and per-counter enable bits, write-one clear bits, the event select fields, an interrupt status bit and a readback of every counter.

When the cycle counter passes its all-ones value, it wraps to zero. The whole unit then freezes, so software can read a consistent snapshot of all four counters, and the interrupt line rises. Clearing counter 0 releases the freeze.

The `stop_mode` input decides what an event counter does when it passes its own maximum. With `stop_mode` low it wraps and keeps going. With `stop_mode` high it sticks at all-ones until it is cleared. An event counter raises no interrupt in either mode.

Top module: `perf_mon`

## Requirements
- R1: After reset, every counter reads 0, the status register reads 0 and `irq` is low.
- R2: Counter 0 (address 4) adds one on every clock edge while the run bit CTRL[0] (address 0) is set and the unit is not frozen.
- R3: Event counter i (i = 1..3, address 4+i) adds one on an edge only when three things hold: the unit is running, CTRL[i] is set, and `evt_in[s]` is high, where s is the 2-bit field SEL[2i-1:2i-2] (address 2). With CTRL[i] clear, its events are ignored.
- R4: Clearing CTRL[0] stops all four counters on the same edge. Their values then hold, and all of them resume together when CTRL[0] is set again.
- R5: An increment of counter 0 from all-ones wraps it to 0 and freezes all counters from the next edge on. The same increment sets STAT[0] (address 3) and drives `irq` high.
- R6: Writing STAT does not release the freeze. Only a write of 1 to CLR[0] (address 1) releases it, and counting resumes on the edge after that write.
- R7: With `stop_mode` low, an event counter that increments from all-ones wraps to 0 and goes on counting.
- R8: With `stop_mode` high, an event counter that reaches all-ones holds that value and ignores further events until a write of 1 to its CLR bit. After that write it counts again from 0.
- R9: An event counter overflow, in either mode, never sets STAT[0] and never drives `irq`.
- R10: Writing 1 to CLR[i] zeroes counter i on that edge. The clear wins over an increment on the same edge.
- R11: `irq` is a level that stays high until a write of 1 to STAT[0]. If a cycle overflow falls on the same edge as that write, the overflow wins.
- R12: CTRL and SEL read back the values last written to them, and `reg_rdata` follows `reg_addr` without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stop_mode | input | 1 | 0: event counters wrap; 1: event counters stick at overflow |
| evt_in | input | NUM_SRC | Event pulses from the memory controller, one bit per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| irq | output | 1 | Cycle counter overflow interrupt, level high |

## Verification
Two pairs of actions can land on the same edge.

The first pair is a clear and an increment of the same counter. The bench provokes it by writing CLR[0] while the cycle counter is running. It then expects the count to restart from zero, so the write edge itself must not be counted. The same run pushes an event counter through its overflow. The result is judged against 302 mod 256 in wrap mode and against a stuck all-ones in stop mode.

The second pair is the freeze and a stream of event pulses. The bench keeps the pulses going into a frozen unit and checks the readback before the freeze is released and after it.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;
  localparam int unsigned REG_CTRL     = 0;
  localparam int unsigned REG_CLR      = 1;
  localparam int unsigned REG_SEL      = 2;
  localparam int unsigned REG_STAT     = 3;
  localparam int unsigned REG_CNT_BASE = 4;
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pm_cycle_ctr.sv
module pm_cycle_ctr #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  output logic [CNT_W-1:0] value,
  output logic             ovf
);
  logic [CNT_W-1:0] val_q, val_d;
  logic             val_en;

  always_comb begin
    val_d  = val_q;
    val_en = clr | tick;
    if (clr)       val_d = '0;
    else if (tick) val_d = val_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_en) val_q <= val_d;
  end

  assign ovf   = tick & ~clr & (&val_q);
  assign value = val_q;
endmodule

// File: rtl/pm_event_ctr.sv
module pm_event_ctr #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             stop_mode,
  output logic [CNT_W-1:0] value
);
  logic [CNT_W-1:0] val_q, val_d;
  logic             halt_q, halt_d;
  logic             hit, upd_en;

  always_comb begin
    hit    = tick & ~halt_q;
    val_d  = val_q;
    halt_d = halt_q;
    upd_en = clr | hit;
    if (clr) begin
      val_d  = '0;
      halt_d = 1'b0;
    end else if (hit) begin
      if (stop_mode && (&val_q)) halt_d = 1'b1;
      else                       val_d  = val_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      halt_q <= 1'b0;
    end else if (upd_en) begin
      val_q  <= val_d;
      halt_q <= halt_d;
    end
  end

  assign value = val_q;
endmodule

// File: rtl/pm_regfile.sv
module pm_regfile
  import perf_mon_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned NUM_CTR = 4,
  parameter int unsigned SEL_W   = 6,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  input  logic                     cyc_ovf,
  input  logic [NUM_CTR*CNT_W-1:0] ctr_flat,
  output logic [NUM_CTR-1:0]       ctrl,
  output logic [SEL_W-1:0]         sel,
  output logic [NUM_CTR-1:0]       clr,
  output logic                     frozen,
  output logic                     irq,
  output logic [DATA_W-1:0]        reg_rdata
);
  logic [NUM_CTR-1:0] ctrl_q;
  logic [SEL_W-1:0]   sel_q;
  logic               frz_q, frz_d;
  logic               irq_q, irq_d;
  logic               wr_ctrl, wr_clr, wr_sel, wr_stat;

  always_comb begin
    wr_ctrl = reg_wr && (reg_addr == ADDR_W'(REG_CTRL));
    wr_clr  = reg_wr && (reg_addr == ADDR_W'(REG_CLR));
    wr_sel  = reg_wr && (reg_addr == ADDR_W'(REG_SEL));
    wr_stat = reg_wr && (reg_addr == ADDR_W'(REG_STAT));
    clr     = wr_clr ? reg_wdata[NUM_CTR-1:0] : '0;
  end

  always_comb begin
    frz_d = frz_q;
    if (cyc_ovf)     frz_d = 1'b1;
    else if (clr[0]) frz_d = 1'b0;
    irq_d = irq_q;
    if (cyc_ovf)                     irq_d = 1'b1;
    else if (wr_stat && reg_wdata[0]) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= reg_wdata[NUM_CTR-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (wr_sel) sel_q <= reg_wdata[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      frz_q <= frz_d;
      irq_q <= irq_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(REG_CTRL)) reg_rdata[NUM_CTR-1:0] = ctrl_q;
    if (reg_addr == ADDR_W'(REG_SEL))  reg_rdata[SEL_W-1:0]   = sel_q;
    if (reg_addr == ADDR_W'(REG_STAT)) reg_rdata[0]           = irq_q;
    for (int k = 0; k < NUM_CTR; k++) begin
      if (reg_addr == ADDR_W'(REG_CNT_BASE + k))
        reg_rdata[CNT_W-1:0] = ctr_flat[k*CNT_W +: CNT_W];
    end
  end

  assign ctrl   = ctrl_q;
  assign sel    = sel_q;
  assign frozen = frz_q;
  assign irq    = irq_q;
endmodule

// File: rtl/perf_mon.sv
module perf_mon #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned NUM_EVT = 3,
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_mode,
  input  logic [NUM_SRC-1:0] evt_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int unsigned NUM_CTR = NUM_EVT + 1;
  localparam int unsigned SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int unsigned SEL_W   = NUM_EVT * SRC_W;

  logic                     rst_sync_n;
  logic [NUM_CTR-1:0]       ctrl;
  logic [SEL_W-1:0]         sel;
  logic [NUM_CTR-1:0]       clr;
  logic                     frozen;
  logic                     run;
  logic                     active;
  logic                     cyc_ovf;
  logic [NUM_CTR*CNT_W-1:0] ctr_flat;

  pm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign run    = ctrl[0];
  assign active = run & ~frozen;

  pm_cycle_ctr #(.CNT_W(CNT_W)) u_cyc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (active),
    .clr   (clr[0]),
    .value (ctr_flat[0 +: CNT_W]),
    .ovf   (cyc_ovf)
  );

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
    logic [SRC_W-1:0] src;
    logic             pulse;
    assign src   = sel[k*SRC_W +: SRC_W];
    assign pulse = evt_in[src];

    pm_event_ctr #(.CNT_W(CNT_W)) u_evt (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .tick      (active & ctrl[k+1] & pulse),
      .clr       (clr[k+1]),
      .stop_mode (stop_mode),
      .value     (ctr_flat[(k+1)*CNT_W +: CNT_W])
    );
  end

  pm_regfile #(
    .CNT_W   (CNT_W),
    .NUM_CTR (NUM_CTR),
    .SEL_W   (SEL_W),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cyc_ovf   (cyc_ovf),
    .ctr_flat  (ctr_flat),
    .ctrl      (ctrl),
    .sel       (sel),
    .clr       (clr),
    .frozen    (frozen),
    .irq       (irq),
    .reg_rdata (reg_rdata)
  );
endmodule

// File: rtl/perf_mon_chk.sv
module perf_mon_chk #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned NUM_EVT = 3,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           reg_wr,
  input logic [ADDR_W-1:0]              reg_addr,
  input logic [DATA_W-1:0]              reg_wdata,
  input logic                           stop_mode,
  input logic                           irq,
  input logic                           frozen,
  input logic                           run,
  input logic [(NUM_EVT+1)*CNT_W-1:0]   ctr_val
);
  logic             clr_wr;
  logic             stat_wr;
  logic [CNT_W-1:0] cyc;

  assign clr_wr  = reg_wr && (reg_addr == ADDR_W'(1));
  assign stat_wr = reg_wr && (reg_addr == ADDR_W'(3)) && reg_wdata[0];
  assign cyc     = ctr_val[0 +: CNT_W];

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    frozen && !clr_wr |=> ctr_val == $past(ctr_val)); // R5

  AST_RUN_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !clr_wr |=> ctr_val == $past(ctr_val)); // R4

  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && reg_wdata[0] |=> cyc == '0); // R10

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !stat_wr |=> irq); // R11

  AST_FREEZE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    frozen && !(clr_wr && reg_wdata[0]) |=> frozen); // R6

  AST_OVF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    run && !frozen && (&cyc) && !(clr_wr && reg_wdata[0]) |=> irq && frozen && cyc == '0); // R5

  for (genvar k = 1; k <= NUM_EVT; k++) begin : g_stop
    AST_STOP_STICK: assert property (@(posedge clk) disable iff (!rst_n)
      stop_mode && (&ctr_val[k*CNT_W +: CNT_W]) && !(clr_wr && reg_wdata[k])
      |=> &ctr_val[k*CNT_W +: CNT_W]); // R8
  end
endmodule

bind perf_mon perf_mon_chk #(
  .CNT_W   (CNT_W),
  .NUM_EVT (NUM_EVT),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .stop_mode (stop_mode),
  .irq       (irq),
  .frozen    (frozen),
  .run       (run),
  .ctr_val   (ctr_flat)
);

// File: tb/test_perf_mon.sv
module test_perf_mon;
  localparam int unsigned CW = 8;
  localparam logic [2:0] A_CTRL = 3'd0, A_CLR = 3'd1, A_SEL = 3'd2, A_STAT = 3'd3;

  logic       clk = 1'b0;
  logic       rst_n, stop_mode, reg_wr;
  logic [3:0] evt_in;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq;

  logic       rd_req, rd_irq, done, wd_hit;
  int         total = 0, bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  perf_mon #(.CNT_W(CW), .DATA_W(8)) i_perf_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_mode (stop_mode),
    .evt_in    (evt_in),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  // monitor: pops the expected item and compares at the falling edge
  always @(negedge clk) begin
    if (rd_req) begin
      logic [7:0] obs, e;
      string      t;
      obs = rd_irq ? {7'b0, irq} : reg_rdata;
      e   = exp_q.pop_front();
      t   = tag_q.pop_front();
      total++;
      if (obs !== e) begin
        bad++;
        $display("FAIL %s: got %0d expected %0d", t, obs, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic chk(input logic [2:0] a, input logic [7:0] e, input string t);
    reg_addr = a; rd_irq = 1'b0;
    exp_q.push_back(e); tag_q.push_back(t);
    rd_req = 1'b1;
    @(posedge clk); #1;
    rd_req = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    rd_irq = 1'b1;
    exp_q.push_back({7'b0, e}); tag_q.push_back(t);
    rd_req = 1'b1;
    @(posedge clk); #1;
    rd_req = 1'b0; rd_irq = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // 302 events with a cycle-counter clear in the middle
  task automatic long_run();
    wr(A_CLR, 8'h0F);
    evt_in = 4'b0010;
    wr(A_CTRL, 8'h05);
    cycles(200);
    wr(A_CLR, 8'h01);
    cycles(100);
    wr(A_CTRL, 8'h00);
    evt_in = 4'b0000;
  endtask

  initial begin
    rst_n = 1'b0; stop_mode = 1'b0; reg_wr = 1'b0; reg_addr = '0;
    reg_wdata = '0; evt_in = '0; rd_req = 1'b0; rd_irq = 1'b0; done = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cycles(3);

    for (int k = 0; k < 4; k++) chk(3'(4 + k), 8'd0, "R1 counter after reset");
    chk(A_STAT, 8'd0, "R1 status after reset");
    chk_irq(1'b0, "R1 irq after reset");

    // sel: ctr1<-src0, ctr2<-src1, ctr3<-src2
    wr(A_SEL, 8'h24);
    evt_in = 4'b0011;
    wr(A_CTRL, 8'h01);
    cycles(9);
    wr(A_CTRL, 8'h00);
    chk(3'd4, 8'd10, "R2 cycle count");
    chk(3'd5, 8'd0, "R3 disabled counter ignores events");

    wr(A_CLR, 8'h0F);
    wr(A_CTRL, 8'h0F);
    cycles(19);
    wr(A_CTRL, 8'h00);
    chk(3'd4, 8'd20, "R4 cycle stops with run");
    chk(3'd5, 8'd20, "R3 ctr1 on src0");
    chk(3'd6, 8'd20, "R3 ctr2 on src1");
    chk(3'd7, 8'd0, "R3 ctr3 on idle src2");
    cycles(5);
    chk(3'd5, 8'd20, "R4 hold while stopped");

    // cycle overflow freeze
    wr(A_CLR, 8'h0F);
    evt_in = 4'b0001;
    wr(A_CTRL, 8'h03);
    cycles(40);
    evt_in = 4'b0000;
    cycles(260);
    evt_in = 4'b0001;
    cycles(10);
    chk(3'd4, 8'd0, "R5 cycle wrapped");
    chk(3'd5, 8'd40, "R5 event frozen");
    chk(A_STAT, 8'd1, "R5 status set");
    chk_irq(1'b1, "R5 irq raised");

    wr(A_STAT, 8'h01);
    chk_irq(1'b0, "R11 irq cleared");
    chk(A_STAT, 8'd0, "R11 status cleared");
    cycles(5);
    chk(3'd5, 8'd40, "R6 still frozen after status clear");
    wr(A_CLR, 8'h01);
    cycles(9);
    wr(A_CTRL, 8'h00);
    evt_in = 4'b0000;
    chk(3'd4, 8'd10, "R6 cycle resumed");
    chk(3'd5, 8'd50, "R6 event resumed");

    // wrap mode
    long_run();
    chk(3'd6, 8'd46, "R7 wrap past maximum");
    chk(3'd4, 8'd101, "R10 clear beats increment");
    chk(A_STAT, 8'd0, "R9 no status on event overflow");
    chk_irq(1'b0, "R9 no irq on event overflow");

    // stop mode
    stop_mode = 1'b1;
    long_run();
    chk(3'd6, 8'd255, "R8 held at maximum");
    chk_irq(1'b0, "R9 no irq in stop mode");
    wr(A_CLR, 8'h04);
    chk(3'd6, 8'd0, "R10 clear of stopped counter");
    evt_in = 4'b0010;
    wr(A_CTRL, 8'h05);
    cycles(4);
    wr(A_CTRL, 8'h00);
    evt_in = 4'b0000;
    chk(3'd6, 8'd5, "R8 counts again after clear");

    chk(A_SEL, 8'h24, "R12 select readback");
    wr(A_CTRL, 8'h0A);
    chk(A_CTRL, 8'h0A, "R12 control readback");

    done = 1'b1;
  end

  initial begin
    wd_hit = 1'b0;
    fork
      wait (done);
      begin
        #(200000 * 20);
        wd_hit = 1'b1;
      end
    join_any
    if (wd_hit) $display("FAIL watchdog: got hang expected completion");
    $display("test done: total=%0d bad=%0d", total + int'(wd_hit), bad + int'(wd_hit));
    $finish;
  end
endmodule